// File: doc/BRIEF.md
# IrDA SIR Frame Deframer

This block sits behind the serial receiver of an infrared SIR link. It takes one decoded character per valid cycle and recovers frames from the character stream. Bytes are ignored until a start flag (0xC0) arrives. Any number of repeated start flags are discarded. The block then removes escape transparency from the body. The frame closes on a stop flag (0xC1). Every de-escaped body byte, including the two received frame-check bytes, leaves on a byte output. An end-of-frame marker is set on the last byte.

The output stream lags the input by one accepted byte. A frame's last byte is only known when the stop flag arrives, so the block holds one byte and marks it as last when the frame ends. When a frame ends, a status register latches three flags: abort, CRC error and length error. The status stays valid until the first body character of the next frame.

The check sequence is the reflected 16-bit CCITT CRC (polynomial 0x8408 in reflected form, preset 0xFFFF). It runs over every forwarded byte, the frame-check bytes included. The frame is good when the final register value is the residue 0xF0B8.

Top module: `sir_deframer`

## Requirements
- R1: After reset, outValid, outLast, statusValid, statusAbort, statusCrcErr and statusLenErr are all 0.
- R2: Outside a frame, every character other than 0xC0 (including 0xC1 and 0x7D) is ignored and produces no output and no status change.
- R3: Start flags 0xC0 that come before the first body character are all discarded, and no flag or escape character is ever forwarded unchanged.
- R4: In the frame body, the escape character 0x7D is dropped and the following character is forwarded XORed with 0x20.
- R5: Each accepted body byte is output (outValid high for one cycle) in the cycle after the next body byte is accepted. The final held byte is output with outLast high in the cycle after the frame-ending character. outLast is never high without outValid.
- R6: The CRC runs over all forwarded bytes, the two check bytes included. A stop flag with a final CRC value other than 0xF0B8 sets statusCrcErr.
- R7: 0x7D followed directly by 0xC1 ends the frame with statusAbort=1, statusCrcErr=0 and statusLenErr=0.
- R8: At most MAX_LEN body bytes are forwarded and included in the CRC. Later body bytes are dropped and make statusLenErr=1 at the stop flag.
- R9: A frame closed by a stop flag with fewer than 2 body bytes (start flag then stop flag included) sets statusLenErr.
- R10: On a frame end, statusValid becomes 1 in the following cycle with the flags for that frame. It returns to 0, with all flags cleared, in the cycle after the first body character of a new frame.
- R11: A 0xC0 inside a frame body, or right after an escape, ends the frame as aborted and opens a new frame that accepts body bytes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | inByte carries a received character this cycle |
| inByte | input | 8 | Received character |
| outValid | output | 1 | outByte is a de-escaped frame byte |
| outByte | output | 8 | De-escaped frame byte |
| outLast | output | 1 | outByte is the last byte of its frame |
| statusValid | output | 1 | Status flags describe the most recent frame |
| statusAbort | output | 1 | Frame ended by abort |
| statusCrcErr | output | 1 | Frame check failed |
| statusLenErr | output | 1 | Frame too long or too short |

## Verification
A wrong parser state appears at the ports at the very next body character. Examples are an escape that stays pending or a body state entered without a start flag. In these cases a flag byte is forwarded, a byte is not XORed, or an output pulse is missing one cycle later. A corrupted hold register or byte counter shows in the next output byte or in the position of outLast. A corrupted CRC register stays hidden until the stop flag, where statusCrcErr is wrong in the following cycle. The bench therefore compares every output on every clock against a queue-based model, so that each fault is caught at its first visible cycle.

// File: rtl/sir_deframer_pkg.sv
package sir_deframer_pkg;
  localparam logic [7:0]  FLAG_START = 8'hC0;
  localparam logic [7:0]  FLAG_STOP  = 8'hC1;
  localparam logic [7:0]  CTRL_ESC   = 8'h7D;
  localparam logic [7:0]  ESC_MASK   = 8'h20;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD   = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;

  typedef enum logic [1:0] {ST_HUNT, ST_OPEN, ST_BODY, ST_ESC} rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic frameStart;
    logic takeByte;
    logic unescape;
    logic endFrame;
    logic abort;
  } ctlStrobe_t;

  function automatic logic [15:0] crcStep(input logic [15:0] crcIn, input logic [7:0] dataIn);
    logic [15:0] c;
    c = crcIn ^ {8'h00, dataIn};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_R) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/sir_deframer_ctrl.sv
module sir_deframer_ctrl
  import sir_deframer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic [7:0] inByte,
  output ctlStrobe_t strobe
);
  rxState_e curState, nxtState;

  always_ff @(posedge clk) begin
    if (!rst_n) curState <= ST_HUNT;
    else        curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    strobe   = '0;
    if (inValid) begin
      case (curState)
        ST_HUNT: begin
          if (inByte == FLAG_START) nxtState = ST_OPEN;
        end
        ST_OPEN: begin
          if (inByte == FLAG_STOP) begin
            strobe.endFrame = 1'b1;
            nxtState = ST_HUNT;
          end else if (inByte != FLAG_START) begin
            strobe.frameStart = 1'b1;
            if (inByte == CTRL_ESC) nxtState = ST_ESC;
            else begin
              strobe.takeByte = 1'b1;
              nxtState = ST_BODY;
            end
          end
        end
        ST_BODY: begin
          if (inByte == FLAG_START) begin
            strobe.endFrame = 1'b1;
            strobe.abort    = 1'b1;
            nxtState = ST_OPEN;
          end else if (inByte == FLAG_STOP) begin
            strobe.endFrame = 1'b1;
            nxtState = ST_HUNT;
          end else if (inByte == CTRL_ESC) begin
            nxtState = ST_ESC;
          end else begin
            strobe.takeByte = 1'b1;
          end
        end
        default: begin // ST_ESC
          if (inByte == FLAG_START || inByte == FLAG_STOP) begin
            strobe.endFrame = 1'b1;
            strobe.abort    = 1'b1;
            nxtState = (inByte == FLAG_START) ? ST_OPEN : ST_HUNT;
          end else begin
            strobe.takeByte = 1'b1;
            strobe.unescape = 1'b1;
            nxtState = ST_BODY;
          end
        end
      endcase
    end
  end

  // R11: a character either extends or closes a frame, never both
  a_r11_take_or_end: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.takeByte && strobe.endFrame));
  // R7: abort only accompanies a frame end
  a_r7_abort_needs_end: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.abort |-> strobe.endFrame);
endmodule

// File: rtl/sir_deframer_dp.sv
module sir_deframer_dp
  import sir_deframer_pkg::*;
#(
  parameter int MAX_LEN = 2050
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] inByte,
  input  ctlStrobe_t strobe,
  output logic       outValid,
  output logic [7:0] outByte,
  output logic       outLast,
  output logic       statusValid,
  output logic       statusAbort,
  output logic       statusCrcErr,
  output logic       statusLenErr
);
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);

  logic [15:0]      crcReg;
  logic [CNT_W-1:0] byteCount;
  logic             overflow;
  logic [7:0]       pendByte;
  logic             pendValid;
  logic [7:0]       dataByte;

  assign dataByte = strobe.unescape ? (inByte ^ ESC_MASK) : inByte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crcReg       <= CRC_PRESET;
      byteCount    <= '0;
      overflow     <= 1'b0;
      pendByte     <= '0;
      pendValid    <= 1'b0;
      outValid     <= 1'b0;
      outByte      <= '0;
      outLast      <= 1'b0;
      statusValid  <= 1'b0;
      statusAbort  <= 1'b0;
      statusCrcErr <= 1'b0;
      statusLenErr <= 1'b0;
    end else begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      if (strobe.frameStart) begin
        statusValid  <= 1'b0;
        statusAbort  <= 1'b0;
        statusCrcErr <= 1'b0;
        statusLenErr <= 1'b0;
      end
      if (strobe.takeByte) begin
        if (byteCount == LIMIT) begin
          overflow <= 1'b1;
        end else begin
          crcReg    <= crcStep(crcReg, dataByte);
          byteCount <= byteCount + 1'b1;
          pendByte  <= dataByte;
          pendValid <= 1'b1;
          if (pendValid) begin
            outValid <= 1'b1;
            outByte  <= pendByte;
          end
        end
      end
      if (strobe.endFrame) begin
        if (pendValid) begin
          outValid <= 1'b1;
          outByte  <= pendByte;
          outLast  <= 1'b1;
        end
        pendValid    <= 1'b0;
        crcReg       <= CRC_PRESET;
        byteCount    <= '0;
        overflow     <= 1'b0;
        statusValid  <= 1'b1;
        statusAbort  <= strobe.abort;
        statusCrcErr <= !strobe.abort && (crcReg != CRC_GOOD);
        statusLenErr <= !strobe.abort && (overflow || byteCount < MIN_LEN);
      end
    end
  end

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    byteCount <= LIMIT);
  a_r5_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    outLast |-> outValid);
  a_r10_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (statusAbort || statusCrcErr || statusLenErr) |-> statusValid);
  a_r7_abort_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    statusAbort |-> (!statusCrcErr && !statusLenErr));
endmodule

// File: rtl/sir_deframer.sv
module sir_deframer
  import sir_deframer_pkg::*;
#(
  parameter int MAX_LEN = 2050
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic [7:0] inByte,
  output logic       outValid,
  output logic [7:0] outByte,
  output logic       outLast,
  output logic       statusValid,
  output logic       statusAbort,
  output logic       statusCrcErr,
  output logic       statusLenErr
);
  ctlStrobe_t strobe;

  sir_deframer_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .inByte  (inByte),
    .strobe  (strobe)
  );

  sir_deframer_dp #(.MAX_LEN(MAX_LEN)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .inByte       (inByte),
    .strobe       (strobe),
    .outValid     (outValid),
    .outByte      (outByte),
    .outLast      (outLast),
    .statusValid  (statusValid),
    .statusAbort  (statusAbort),
    .statusCrcErr (statusCrcErr),
    .statusLenErr (statusLenErr)
  );

  // R5: an output byte is always triggered by an input character
  a_r5_out_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(inValid));
endmodule

// File: tb/tb_sir_deframer.sv
module tb_sir_deframer;
  localparam int MAXLEN = 16;
  typedef logic [7:0] bq_t[$];

  logic clk = 0, rst_n = 0, inValid = 0;
  logic [7:0] inByte = 0;
  logic outValid, outLast, statusValid, statusAbort, statusCrcErr, statusLenErr;
  logic [7:0] outByte;

  sir_deframer #(.MAX_LEN(MAXLEN)) dut (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0, lastCount = 0;
  bit done = 0;
  bq_t outQ;

  // reference model state
  int mState = 0; // 0 idle, 1 opened, 2 body, 3 after escape
  bq_t mQ;
  bit mOvf = 0;
  bit eOutValid = 0, eOutLast = 0, eStV = 0, eAb = 0, eCrc = 0, eLen = 0;
  logic [7:0] eOutByte = 0;

  function automatic logic [15:0] crcOf(bq_t q);
    logic [15:0] c = 16'hFFFF;
    foreach (q[k]) begin
      for (int i = 0; i < 8; i++) begin
        bit fb = c[0] ^ q[k][i];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    return c;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic mPush(logic [7:0] d);
    if (mQ.size() == MAXLEN) mOvf = 1;
    else begin
      if (mQ.size() > 0) begin eOutValid = 1; eOutByte = mQ[$]; end
      mQ.push_back(d);
    end
  endtask

  task automatic mFinish(bit ab);
    if (mQ.size() > 0) begin eOutValid = 1; eOutByte = mQ[$]; eOutLast = 1; end
    eStV = 1; eAb = ab;
    eCrc = !ab && (crcOf(mQ) != 16'hF0B8);
    eLen = !ab && (mOvf || mQ.size() < 2);
    mQ.delete(); mOvf = 0;
  endtask

  task automatic mOpenBody();
    eStV = 0; eAb = 0; eCrc = 0; eLen = 0;
  endtask

  task automatic modelStep(bit v, logic [7:0] b);
    eOutValid = 0; eOutLast = 0;
    if (!v) return;
    case (mState)
      0: if (b == 8'hC0) mState = 1;
      1: if (b == 8'hC1) begin mFinish(0); mState = 0; end
         else if (b != 8'hC0) begin
           mOpenBody();
           if (b == 8'h7D) mState = 3; else begin mPush(b); mState = 2; end
         end
      2: if (b == 8'hC0) begin mFinish(1); mState = 1; end
         else if (b == 8'hC1) begin mFinish(0); mState = 0; end
         else if (b == 8'h7D) mState = 3;
         else mPush(b);
      default: if (b == 8'hC1) begin mFinish(1); mState = 0; end
         else if (b == 8'hC0) begin mFinish(1); mState = 1; end
         else begin mPush(b ^ 8'h20); mState = 2; end
    endcase
  endtask

  task automatic compareAll();
    bit okOut = (outValid === eOutValid) && (outLast === eOutLast) &&
                (!eOutValid || outByte === eOutByte);
    chk(okOut, "R5", "out {valid,last,byte}",
        {outValid, outLast, outByte}, {eOutValid, eOutLast, eOutByte});
    chk({statusValid, statusAbort, statusCrcErr, statusLenErr} === {eStV, eAb, eCrc, eLen},
        "R10", "status {valid,abort,crc,len}",
        {statusValid, statusAbort, statusCrcErr, statusLenErr}, {eStV, eAb, eCrc, eLen});
    if (outValid === 1'b1) outQ.push_back(outByte);
    if (outLast === 1'b1) lastCount++;
  endtask

  task automatic step(bit v, logic [7:0] b);
    @(negedge clk);
    compareAll();
    inValid = v; inByte = b;
    modelStep(v, b);
  endtask

  task automatic sendFrame(bq_t data, int nStart, bit badFcs);
    bq_t full = data;
    logic [15:0] fcs = ~crcOf(data);
    if (badFcs) fcs[0] = ~fcs[0];
    full.push_back(fcs[7:0]);
    full.push_back(fcs[15:8]);
    for (int i = 0; i < nStart; i++) step(1, 8'hC0);
    foreach (full[k]) begin
      if (full[k] == 8'hC0 || full[k] == 8'hC1 || full[k] == 8'h7D) begin
        step(1, 8'h7D); step(1, full[k] ^ 8'h20);
      end else step(1, full[k]);
      if (k % 3 == 2) step(0, 0);
    end
    step(1, 8'hC1);
    step(0, 0); step(0, 0);
  endtask

  function automatic bit sameQ(bq_t a, bq_t b);
    if (a.size() != b.size()) return 0;
    foreach (a[k]) if (a[k] !== b[k]) return 0;
    return 1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bq_t d1, exp1, d2, big;
    logic [15:0] f;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk({outValid, outLast, statusValid, statusAbort, statusCrcErr, statusLenErr} === 6'b0,
        "R1", "reset outputs", {outValid, outLast, statusValid, statusAbort, statusCrcErr, statusLenErr}, 0);

    // R2: garbage outside a frame
    outQ.delete();
    step(1, 8'h11); step(1, 8'hC1); step(1, 8'h7D); step(1, 8'h33); step(0, 0); step(0, 0);
    chk(outQ.size() == 0 && statusValid === 0, "R2", "idle garbage output count", outQ.size(), 0);

    // R3 R4 R6: good frame with specials and several start flags
    d1 = '{8'h03, 8'h3F, 8'hC0, 8'h7D, 8'hC1, 8'h41, 8'h42};
    f = ~crcOf(d1);
    exp1 = d1; exp1.push_back(f[7:0]); exp1.push_back(f[15:8]);
    outQ.delete(); lastCount = 0;
    sendFrame(d1, 3, 0);
    chk(sameQ(outQ, exp1), "R3", "de-escaped stream size", outQ.size(), exp1.size());
    chk(lastCount == 1, "R5", "outLast pulses", lastCount, 1);
    chk(statusValid === 1 && statusCrcErr === 0 && statusLenErr === 0 && statusAbort === 0,
        "R6", "good frame flags", {statusValid, statusAbort, statusCrcErr, statusLenErr}, 4'b1000);

    // R6: corrupted FCS
    sendFrame(d1, 1, 1);
    chk(statusCrcErr === 1 && statusLenErr === 0, "R6", "bad fcs crcErr", statusCrcErr, 1);

    // R10: status clears after first body char; R7: escape then stop aborts
    outQ.delete(); lastCount = 0;
    step(1, 8'hC0); step(1, 8'h10); step(0, 0);
    chk(statusValid === 0, "R10", "status cleared on new frame", statusValid, 0);
    step(1, 8'h20); step(1, 8'h7D); step(1, 8'hC1); step(0, 0); step(0, 0);
    chk(statusAbort === 1 && statusCrcErr === 0 && statusLenErr === 0 && statusValid === 1,
        "R7", "abort flags", {statusValid, statusAbort, statusCrcErr, statusLenErr}, 4'b1100);
    chk(sameQ(outQ, '{8'h10, 8'h20}) && lastCount == 1, "R7", "abort stream size", outQ.size(), 2);

    // R11: start flag inside body aborts, then new frame
    step(1, 8'hC0); step(1, 8'hA1); step(1, 8'hA2); step(1, 8'hC0); step(0, 0); step(0, 0);
    chk(statusAbort === 1 && statusValid === 1, "R11", "restart abort", statusAbort, 1);
    d2 = '{8'hB1, 8'hB2, 8'hB3};
    sendFrame(d2, 0, 0);
    chk(statusAbort === 0 && statusCrcErr === 0 && statusLenErr === 0, "R11", "frame after restart",
        {statusAbort, statusCrcErr, statusLenErr}, 0);

    // R8: overlong frame
    for (int i = 0; i < MAXLEN + 4; i++) big.push_back(8'(i + 1));
    outQ.delete();
    sendFrame(big, 1, 0);
    chk(statusLenErr === 1, "R8", "overflow lenErr", statusLenErr, 1);
    chk(outQ.size() == MAXLEN, "R8", "forwarded count", outQ.size(), MAXLEN);

    // R9: empty and one-byte frames; R4 escape of ordinary byte
    step(1, 8'hC0); step(1, 8'hC1); step(0, 0); step(0, 0);
    chk(statusLenErr === 1 && statusValid === 1, "R9", "empty frame lenErr", statusLenErr, 1);
    outQ.delete();
    step(1, 8'hC0); step(1, 8'h7D); step(1, 8'h75); step(1, 8'hC1); step(0, 0); step(0, 0);
    chk(statusLenErr === 1, "R9", "one-byte frame lenErr", statusLenErr, 1);
    chk(outQ.size() == 1 && outQ[0] == 8'h55, "R4", "escaped byte value",
        outQ.size() ? outQ[0] : 0, 8'h55);

    // back-to-back good frame after all that
    sendFrame(d2, 2, 0);
    chk(statusCrcErr === 0 && statusValid === 1, "R6", "final good frame", statusCrcErr, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule